// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flags

This block computes the arithmetic and logic operations of a small 8-bit accumulator machine. Each cycle it takes the current accumulator byte, a second operand byte, the present flag byte and a 4-bit operation code. It returns the result byte, a strobe saying whether the accumulator should be written, and the complete new flag byte. All the arithmetic is combinational. One register stage then captures the result, the strobe and the flags on the rising clock edge, so each answer appears one cycle after its inputs.

There are ten operations: add, add with carry-in, subtract, subtract with borrow-in, compare, AND, XOR, OR, increment and decrement. Every flag follows its own rule for each operation class. The bit at position 2 means signed overflow for the arithmetic class and for increment and decrement. For the logic class the same bit means even parity. The two unused flag positions are always driven low. Register storage, instruction decode and decimal adjust are handled elsewhere.

Top module: `acc_alu`

## Requirements
- R1: The flag byte is laid out as sign at bit 7, zero at bit 6, half-carry at bit 4, parity/overflow at bit 2, subtract at bit 1 and carry at bit 0. Bits 5 and 3 of flags_o are always 0.
- R2: For op 0 (add) and op 1 (add with carry-in), the result is acc + opnd + cin, where cin is flags_i[0] for op 1 and 0 for op 0. Carry is set when the unsigned sum exceeds 0xFF. Half-carry is set when the low-nibble sum plus cin exceeds 0xF. Overflow is set when the signed sum lies outside -128..127. N is cleared.
- R3: For op 2 (subtract) and op 3 (subtract with borrow-in), the result is acc - opnd - cin, where cin is flags_i[0] for op 3 only. Carry is set when acc < opnd + cin, unsigned. Half-carry is set when the low nibble of acc is below the low nibble of opnd plus cin. Overflow is set on a signed result outside -128..127. N is set.
- R4: For op 4 (compare), flags_o equals the flags of op 2 on the same inputs, res_o equals acc_i, and wr_en_o is 0.
- R5: Op 5 (AND), op 6 (XOR) and op 7 (OR) write the bitwise result. They clear carry and N and set bit 2 when the result has an even number of ones. Half-carry is 1 for AND and 0 for XOR and OR.
- R6: Op 8 (increment) and op 9 (decrement) act on acc_i and copy flags_i[0] into carry. Increment clears N, sets overflow when the result is 0x80, and sets half-carry when the result's low nibble is 0x0. Decrement sets N, sets overflow when the result is 0x7F, and sets half-carry when the result's low nibble is 0xF.
- R7: Zero is set exactly when the result (for compare, the difference) is 0. Sign equals bit 7 of that same value.
- R8: Outputs change only on a rising clock edge and show the inputs present at that edge. While rst_ni is low, res_o, wr_en_o and flags_o are 0.
- R9: Op codes 10 to 15 give wr_en_o = 0, res_o = acc_i, and flags_o = flags_i with bits 5 and 3 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 8 | Incoming flag byte |
| res_o | output | 8 | Registered result |
| wr_en_o | output | 1 | Registered accumulator write strobe |
| flags_o | output | 8 | Registered new flag byte |

## Verification
The bench works on the boundaries where each flag changes state, and checks each one against a model computed from integers.

- **Signed overflow.** 0x7F+1, 0x80-1 and carry-in pushing a sum across the signed limit all test the overflow rule. A design that derives overflow from the unsigned carry would flag 0xFF+1 and miss 0x7F+1.
- **Borrow-in.** Subtract-with-borrow and compare are tested with nibble borrows in both directions. A design that leaves cin out of the half-carry or carry compare would be wrong exactly when the operands are equal.
- **Parity versus overflow on bit 2.** Logic operations are run on results of odd and even weight, which exposes a design that reports overflow instead of parity there.
- **Increment and decrement.** These are checked at 0x7F, 0x80, 0x00, 0xFF and at nibble wraps. A version that touches carry would show up as a carry bit that does not follow flags_i[0].

## Flag byte layout

| Bit | Flag |
|---|---|
| 7 | Sign |
| 6 | Zero |
| 5 | Always 0 |
| 4 | Half-carry |
| 3 | Always 0 |
| 2 | Parity/overflow |
| 1 | Subtract (N) |
| 0 | Carry |

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 4;
  localparam int FLAG_W = 8;
  localparam int NIB_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CMP = 4'd4,
    OP_AND = 4'd5,
    OP_XOR = 4'd6,
    OP_OR  = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9
  } alu_op_e;

  localparam int FL_C  = 0;
  localparam int FL_N  = 1;
  localparam int FL_PV = 2;
  localparam int FL_H  = 4;
  localparam int FL_Z  = 6;
  localparam int FL_S  = 7;

  localparam logic [FLAG_W-1:0] FL_UNUSED = 8'h28;

  localparam logic [1:0] LG_AND = 2'd0;
  localparam logic [1:0] LG_XOR = 2'd1;
  localparam logic [1:0] LG_OR  = 2'd2;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              h_o,
  output logic              v_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] full;
  logic [NIB_W:0]  low;

  always_comb begin
    if (sub_i) begin
      full = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_i};
      low  = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin_i};
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
      low  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin_i};
    end
  end

  assign res_o = full[DATA_W-1:0];
  // top bit of a 1-bit-extended op is carry for add, borrow for subtract
  assign c_o = full[DATA_W];
  assign h_o = low[NIB_W];
  // signed overflow: operands agree (add) or differ (sub) in sign and result sign flips
  assign v_o = ((a_i[MSB] ^ b_i[MSB]) == sub_i) && (res_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        sel_i,
  output logic [DATA_W-1:0] res_o,
  output logic              h_o,
  output logic              par_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i | b_i;
    endcase
  end

  assign h_o   = (sel_i == LG_AND);
  assign par_o = ~^res_o;
endmodule

// File: rtl/acc_alu_step.sv
module acc_alu_step
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              dec_i,
  output logic [DATA_W-1:0] res_o,
  output logic              h_o,
  output logic              v_o
);
  localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};

  assign res_o = dec_i ? (a_i - ONE) : (a_i + ONE);
  assign h_o   = dec_i ? (res_o[NIB_W-1:0] == {NIB_W{1'b1}})
                       : (res_o[NIB_W-1:0] == {NIB_W{1'b0}});
  assign v_o   = dec_i ? (res_o == SMAX) : (res_o == SMIN);
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_en_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int MSB = DATA_W - 1;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic as_sub, as_cin;
  logic [DATA_W-1:0] as_res, lg_res, st_res;
  logic as_c, as_h, as_v, lg_h, lg_par, st_h, st_v;
  logic [1:0] lg_sel;

  assign as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign as_cin = ((op == OP_ADC) || (op == OP_SBC)) && flags_i[FL_C];

  always_comb begin
    unique case (op)
      OP_XOR:  lg_sel = LG_XOR;
      OP_OR:   lg_sel = LG_OR;
      default: lg_sel = LG_AND;
    endcase
  end

  acc_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i(acc_i), .b_i(opnd_i), .cin_i(as_cin), .sub_i(as_sub),
    .res_o(as_res), .c_o(as_c), .h_o(as_h), .v_o(as_v)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i(acc_i), .b_i(opnd_i), .sel_i(lg_sel),
    .res_o(lg_res), .h_o(lg_h), .par_o(lg_par)
  );

  acc_alu_step #(.DATA_W(DATA_W)) u_step (
    .a_i(acc_i), .dec_i(op == OP_DEC),
    .res_o(st_res), .h_o(st_h), .v_o(st_v)
  );

  logic [DATA_W-1:0] res_d, zs_src;
  logic              wr_d, pass_d;
  logic              c_d, h_d, pv_d, n_d;
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    res_d  = acc_i;
    zs_src = acc_i;
    wr_d   = 1'b0;
    pass_d = 1'b0;
    c_d    = flags_i[FL_C];
    h_d    = 1'b0;
    pv_d   = 1'b0;
    n_d    = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res_d = as_res; zs_src = as_res; wr_d = 1'b1;
        c_d = as_c; h_d = as_h; pv_d = as_v; n_d = as_sub;
      end
      OP_CMP: begin
        zs_src = as_res;
        c_d = as_c; h_d = as_h; pv_d = as_v; n_d = 1'b1;
      end
      OP_AND, OP_XOR, OP_OR: begin
        res_d = lg_res; zs_src = lg_res; wr_d = 1'b1;
        c_d = 1'b0; h_d = lg_h; pv_d = lg_par;
      end
      OP_INC, OP_DEC: begin
        res_d = st_res; zs_src = st_res; wr_d = 1'b1;
        h_d = st_h; pv_d = st_v; n_d = (op == OP_DEC);
      end
      default: pass_d = 1'b1;
    endcase
  end

  always_comb begin
    if (pass_d) begin
      flags_d = flags_i & ~FL_UNUSED;
    end else begin
      flags_d        = '0;
      flags_d[FL_S]  = zs_src[MSB];
      flags_d[FL_Z]  = (zs_src == '0);
      flags_d[FL_H]  = h_d;
      flags_d[FL_PV] = pv_d;
      flags_d[FL_N]  = n_d;
      flags_d[FL_C]  = c_d;
    end
  end

  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      wr_en_o <= 1'b0;
      flags_o <= '0;
      seen_q  <= 1'b0;
    end else begin
      res_o   <= res_d;
      wr_en_o <= wr_d;
      flags_o <= flags_d;
      seen_q  <= 1'b1;
    end
  end

  p_undoc_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0));

  p_add_n_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && ($past(op_i) == OP_ADD || $past(op_i) == OP_ADC) |-> !flags_o[FL_N]);

  p_sub_n_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && ($past(op_i) == OP_SUB || $past(op_i) == OP_SBC) |-> flags_o[FL_N]);

  p_cmp_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && ($past(op_i) == OP_CMP) |-> !wr_en_o && (res_o == $past(acc_i)));

  p_logic_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && ($past(op_i) == OP_AND || $past(op_i) == OP_XOR || $past(op_i) == OP_OR)
    |-> !flags_o[FL_C] && !flags_o[FL_N]);

  p_step_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC)
    |-> flags_o[FL_C] == $past(flags_i[FL_C]));

  p_zero_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (flags_o[FL_Z] == (res_o == '0)) && (flags_o[FL_S] == res_o[MSB]));

  p_undef_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && ($past(op_i) > 4'd9) |-> !wr_en_o && (flags_o == ($past(flags_i) & 8'hD7)));
endmodule

// File: tb/acc_alu_test.sv
`timescale 1ns/100ps
module acc_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] acc = '0, opnd = '0, fin = '0;
  logic [7:0] res, flg;
  logic       wr;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  acc_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .acc_i(acc), .opnd_i(opnd),
    .flags_i(fin), .res_o(res), .wr_en_o(wr), .flags_o(flg)
  );

  function automatic int sgn(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic void model(input int o, input int a, input int b, input int f,
                                output int r, output int w, output int fl);
    int cin, t, s, z, h, p, n, c, zs;
    c = f & 1; h = 0; p = 0; n = 0; w = 1; r = a; zs = a;
    case (o)
      0, 1: begin
        cin = (o == 1) ? (f & 1) : 0;
        t = a + b + cin; r = t & 255; zs = r;
        c = (t > 255); h = ((a & 15) + (b & 15) + cin) > 15;
        s = sgn(a) + sgn(b) + cin; p = (s < -128) || (s > 127);
      end
      2, 3, 4: begin
        cin = (o == 3) ? (f & 1) : 0;
        t = a - b - cin; zs = t & 255; r = (o == 4) ? a : zs; w = (o != 4);
        c = a < (b + cin); h = (a & 15) < ((b & 15) + cin); n = 1;
        s = sgn(a) - sgn(b) - cin; p = (s < -128) || (s > 127);
      end
      5, 6, 7: begin
        r = (o == 5) ? (a & b) : (o == 6) ? (a ^ b) : (a | b); zs = r;
        c = 0; h = (o == 5); p = ($countones(r[7:0]) % 2) == 0;
      end
      8: begin r = (a + 1) & 255; zs = r; p = (r == 128); h = (r & 15) == 0; end
      9: begin r = (a + 255) & 255; zs = r; p = (r == 127); h = (r & 15) == 15; n = 1; end
      default: begin w = 0; fl = f & 8'hD7; return; end
    endcase
    z = (zs == 0); s = (zs >> 7) & 1;
    fl = (s << 7) | (z << 6) | (h << 4) | (p << 2) | (n << 1) | c;
  endfunction

  task automatic expect_out(input string tag, input int er, input int ew, input int ef);
    n_run++;
    if (res !== er[7:0] || wr !== ew[0] || flg !== ef[7:0]) begin
      n_fail++;
      $display("FAIL %s: got res=%h wr=%b flags=%h, expected res=%h wr=%b flags=%h",
               tag, res, wr, flg, er[7:0], ew[0], ef[7:0]);
    end
  endtask

  task automatic apply(input string tag, input int o, input int a, input int b, input int f);
    int er, ew, ef;
    @(negedge clk);
    op = o[3:0]; acc = a[7:0]; opnd = b[7:0]; fin = f[7:0];
    model(o, a, b, f, er, ew, ef);
    @(posedge clk); #1;
    expect_out(tag, er, ew, ef);
  endtask

  task automatic t_reset;  // R8
    op = 4'd0; acc = 8'h55; opnd = 8'h66; fin = 8'hFF;
    repeat (3) @(posedge clk);
    #1 expect_out("R8 reset", 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_latency;  // R8
    apply("R8 first", 0, 8'h10, 8'h20, 0);
    @(negedge clk);
    op = 4'd5; acc = 8'hF0; opnd = 8'h0F;
    #1 expect_out("R8 hold before edge", 8'h30, 1, 8'h00);
    @(posedge clk); #1;
    expect_out("R8 after edge", 0, 1, 8'h54);
  endtask

  task automatic t_add;  // R2 R7
    apply("R2 7f+1", 0, 8'h7F, 8'h01, 0);
    apply("R2 ff+1", 0, 8'hFF, 8'h01, 0);
    apply("R2 0f+1", 0, 8'h0F, 8'h01, 0);
    apply("R2 adc cin", 1, 8'h7F, 8'h00, 1);
    apply("R2 adc ff+ff+c", 1, 8'hFF, 8'hFF, 1);
    apply("R2 add ignores c", 0, 8'h7F, 8'h00, 1);
    apply("R7 80+80", 0, 8'h80, 8'h80, 0);
    for (int i = 0; i < 24; i++)
      apply("R2 sweep", i % 2, (i * 53 + 7) & 255, (i * 29 + 200) & 255, i & 1);
  endtask

  task automatic t_sub;  // R3
    apply("R3 80-1", 2, 8'h80, 8'h01, 0);
    apply("R3 0-1", 2, 8'h00, 8'h01, 0);
    apply("R3 10-1", 2, 8'h10, 8'h01, 0);
    apply("R3 sbc eq", 3, 8'h42, 8'h42, 1);
    apply("R3 sbc nib", 3, 8'h30, 8'h00, 1);
    apply("R3 sub ignores c", 2, 8'h42, 8'h42, 1);
    for (int i = 0; i < 24; i++)
      apply("R3 sweep", 2 + (i % 2), (i * 71 + 3) & 255, (i * 37 + 90) & 255, (i >> 1) & 1);
  endtask

  task automatic t_cmp;  // R4
    apply("R4 eq", 4, 8'h5A, 8'h5A, 0);
    apply("R4 lt", 4, 8'h01, 8'h02, 0);
    apply("R4 ovf", 4, 8'h80, 8'h01, 1);
    for (int i = 0; i < 12; i++)
      apply("R4 sweep", 4, (i * 97 + 11) & 255, (i * 45 + 33) & 255, i & 1);
  endtask

  task automatic t_logic;  // R5
    apply("R5 and zero", 5, 8'hF0, 8'h0F, 1);
    apply("R5 and odd", 5, 8'hFF, 8'h01, 0);
    apply("R5 xor even", 6, 8'hFF, 8'h0F, 1);
    apply("R5 or odd", 7, 8'h80, 8'h03, 1);
    for (int i = 0; i < 18; i++)
      apply("R5 sweep", 5 + (i % 3), (i * 83 + 19) & 255, (i * 61 + 5) & 255, 8'h13);
  endtask

  task automatic t_step;  // R6
    apply("R6 inc 7f", 8, 8'h7F, 0, 1);
    apply("R6 inc ff", 8, 8'hFF, 0, 0);
    apply("R6 inc 0e", 8, 8'h0E, 0, 1);
    apply("R6 dec 80", 9, 8'h80, 0, 0);
    apply("R6 dec 00", 9, 8'h00, 0, 1);
    apply("R6 dec 01", 9, 8'h01, 0, 0);
    apply("R6 dec 10", 9, 8'h10, 0, 1);
    for (int i = 0; i < 16; i++)
      apply("R6 sweep", 8 + (i % 2), (i * 113 + 1) & 255, 0, i & 1);
  endtask

  task automatic t_undef;  // R9 R1
    for (int o = 10; o < 16; o++)
      apply("R9 unused op", o, 8'hA5, 8'h3C, 8'hFF);
    apply("R1 unused bits", 10, 8'h00, 8'h00, 8'h28);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_step();
    t_undef();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule